// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Controller

This block gathers up to 32 interrupt sources and presents them to a processor as two request lines and one wake line. Each source selects its own trigger mode. A 3-bit code chooses rising edge, falling edge, both edges, active-high level, active-low level or off. The three bits of the code sit in three separate configuration registers, one bit per source in each. Every source passes through a two-flop synchroniser. An edge on a source is latched in a sticky capture register, and software clears it by writing ones.

Software programs the block over a plain register bus. The bus has a one-cycle write strobe and a one-cycle read strobe, and read data is registered. Most registers are set/clear pairs. Writing ones at the set address sets bits, and writing ones at the address 4 bytes higher clears them. Zero bits in the write data leave state unchanged, and the value reads back at the set address. A per-source routing bit chooses the request line the source drives. A mask bit gates whether the source reaches its request line. A wake-enable bit gates the wake line on its own, independently of the mask. Software reads one pending vector per request line to find which source fired.

Top module: `irqc_top`

## Requirements
- R1: After synchronous reset the following read as zero: the three config registers, the assign, wake-enable and mask registers, both capture registers and the test register (0x80). The source-select register (0x58) reads all ones. The irq0, irq1 and wake outputs are low.
- R2: The set/clear pairs are config0 0x40/0x44, config1 0x48/0x4C, config2 0x50/0x54, source select 0x58/0x5C, assign 0x60/0x64, wake enable 0x68/0x6C and mask 0x70/0x74. Writing ones at the first address of a pair sets those bits, writing ones at the second clears them, and zero bits change nothing. The value reads at the first address. The test register at 0x80 is written whole and reads back.
- R3: A source's trigger code is {config2, config1, config0} bit n. Code 001 latches rising edges into the rise capture register (read 0x78) and makes the source pending while that bit is set. Code 010 does the same with falling edges and the fall capture register (read 0x7C). Code 011 latches both edges.
- R4: Code 101 makes the source pending exactly while its synchronised input is high, and code 110 while it is low. Nothing is latched in either level mode.
- R5: In code 011 the source stays pending until both its rise and its fall capture bits are clear.
- R6: Writing ones to 0x78 or 0x7C clears the matching rise or fall capture bits, and writing zeros leaves them unchanged.
- R7: A source whose assign bit is 1 routes to irq0, and a source whose assign bit is 0 routes to irq1. A read of 0x54 returns the pending, unmasked sources routed to irq0, and a read of 0x5C returns those routed to irq1. irq0 is high when the 0x54 vector is nonzero, and irq1 when the 0x5C vector is nonzero.
- R8: A clear mask bit keeps its source off both request lines and out of both pending vectors. wake is high when any pending source has its wake-enable bit set, whatever its mask bit.
- R9: Reads of unmapped addresses, including the clear-only addresses 0x44, 0x4C, 0x64, 0x6C and 0x74, return zero. Writes to unmapped addresses change no state.
- R10: Codes 000, 100 and 111 never make a source pending and never latch an edge.
- R11: An input change made between clock edges reaches irq0, irq1 or wake on the third rising edge in a level mode. In an edge mode it reaches them on the fourth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NSRC | Asynchronous interrupt source lines |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | NSRC | Write data |
| rdata | output | NSRC | Read data, valid the cycle after rd_en |
| irq0 | output | 1 | Request line 0 (sources with assign = 1) |
| irq1 | output | 1 | Request line 1 (sources with assign = 0) |
| wake | output | 1 | Wake request |

## Verification
The hardest case to reach from the ports is the both-edges mode with exactly one capture bit left set. Reaching it takes a full rising-then-falling sequence on the source, then a clear of only one capture register. Only then can the bench see whether the pending bit honours the other capture bit. The bench sweeps all eight trigger codes against both routing values on one source. It walks each combination through idle, rise, fall, rise-clear and fall-clear. After every step it compares both pending vectors, both capture reads and the three outputs against a mode table the bench computes itself.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Set/clear bank layout: register i is set at SC_BASE + 8*i, cleared at +4
  localparam int unsigned NUM_SC    = 7;
  localparam int unsigned SC_CFG0   = 0;
  localparam int unsigned SC_CFG1   = 1;
  localparam int unsigned SC_CFG2   = 2;
  localparam int unsigned SC_SRCSEL = 3;
  localparam int unsigned SC_ASSIGN = 4;
  localparam int unsigned SC_WAKE   = 5;
  localparam int unsigned SC_MASK   = 6;

  localparam int unsigned SC_BASE    = 'h40;
  localparam int unsigned SC_STRIDE  = 8;
  localparam int unsigned CLR_OFS    = 4;
  localparam int unsigned PEND0_ADDR = 'h54;
  localparam int unsigned PEND1_ADDR = 'h5C;
  localparam int unsigned RISE_ADDR  = 'h78;
  localparam int unsigned FALL_ADDR  = 'h7C;
  localparam int unsigned TEST_ADDR  = 'h80;

  typedef enum logic [2:0] {
    TRIG_OFF  = 3'b000,
    TRIG_RISE = 3'b001,
    TRIG_FALL = 3'b010,
    TRIG_BOTH = 3'b011,
    TRIG_HIGH = 3'b101,
    TRIG_LOW  = 3'b110
  } trig_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irqc_scbank.sv
module irqc_scbank
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [NSRC-1:0]                wdata,
  output logic [NUM_SC-1:0][NSRC-1:0]    q
);
  genvar i;
  generate
    for (i = 0; i < NUM_SC; i++) begin : g_reg
      localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SC_BASE + SC_STRIDE * i);
      localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(SC_BASE + SC_STRIDE * i + CLR_OFS);
      localparam logic [NSRC-1:0]   RST_V = (i == SC_SRCSEL) ? '1 : '0;
      logic set_hit, clr_hit;
      assign set_hit = wr_en && (addr == SET_A);
      assign clr_hit = wr_en && (addr == CLR_A);
      always_ff @(posedge clk) begin
        if (rst)          q[i] <= RST_V;
        else if (set_hit) q[i] <= q[i] | wdata;
        else if (clr_hit) q[i] <= q[i] & ~wdata;
      end
    end
  endgenerate
endmodule

// File: rtl/irqc_src_cell.sv
module irqc_src_cell
  import irqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       s_in,
  input  logic [2:0] code,
  input  logic       clr_rise,
  input  logic       clr_fall,
  output logic       rise_q,
  output logic       fall_q,
  output logic       rise_ok,
  output logic       pend
);
  logic prev_q;
  logic fall_ok;
  logic rise_ev, fall_ev;

  assign rise_ok = ~code[2] & code[0];
  assign fall_ok = ~code[2] & code[1];
  assign rise_ev = s_in & ~prev_q;
  assign fall_ev = ~s_in & prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      prev_q <= s_in;
      // a fresh edge wins over a clear in the same cycle
      rise_q <= (rise_q & ~clr_rise) | (rise_ok & rise_ev);
      fall_q <= (fall_q & ~clr_fall) | (fall_ok & fall_ev);
    end
  end

  always_comb begin
    case (trig_e'(code))
      TRIG_RISE: pend = rise_q;
      TRIG_FALL: pend = fall_q;
      TRIG_BOTH: pend = rise_q | fall_q;
      TRIG_HIGH: pend = s_in;
      TRIG_LOW:  pend = ~s_in;
      default:   pend = 1'b0;
    endcase
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC        = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSRC-1:0]   wdata,
  output logic [NSRC-1:0]   rdata,
  output logic              irq0,
  output logic              irq1,
  output logic              wake
);
  localparam logic [ADDR_W-1:0] A_PEND0 = ADDR_W'(PEND0_ADDR);
  localparam logic [ADDR_W-1:0] A_PEND1 = ADDR_W'(PEND1_ADDR);
  localparam logic [ADDR_W-1:0] A_RISE  = ADDR_W'(RISE_ADDR);
  localparam logic [ADDR_W-1:0] A_FALL  = ADDR_W'(FALL_ADDR);
  localparam logic [ADDR_W-1:0] A_TEST  = ADDR_W'(TEST_ADDR);

  logic [NSRC-1:0]               s_sync;
  logic [NUM_SC-1:0][NSRC-1:0]   bank_q;
  logic [NSRC-1:0]               mask_q, assign_q, wake_q;
  logic [NSRC-1:0]               rise_cap, fall_cap, rise_ok, pend;
  logic [NSRC-1:0]               clr_rise_v, clr_fall_v;
  logic [NSRC-1:0]               req0_vec, req1_vec, wake_vec;
  logic [NSRC-1:0]               test_q;
  logic [NSRC-1:0]               rd_mux;

  irqc_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d (src_in), .q (s_sync)
  );

  irqc_scbank #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_bank (
    .clk (clk), .rst (rst), .wr_en (wr_en), .addr (addr),
    .wdata (wdata), .q (bank_q)
  );

  assign mask_q   = bank_q[SC_MASK];
  assign assign_q = bank_q[SC_ASSIGN];
  assign wake_q   = bank_q[SC_WAKE];

  assign clr_rise_v = (wr_en && addr == A_RISE) ? wdata : '0;
  assign clr_fall_v = (wr_en && addr == A_FALL) ? wdata : '0;

  genvar n;
  generate
    for (n = 0; n < NSRC; n++) begin : g_src
      irqc_src_cell u_cell (
        .clk      (clk),
        .rst      (rst),
        .s_in     (s_sync[n]),
        .code     ({bank_q[SC_CFG2][n], bank_q[SC_CFG1][n], bank_q[SC_CFG0][n]}),
        .clr_rise (clr_rise_v[n]),
        .clr_fall (clr_fall_v[n]),
        .rise_q   (rise_cap[n]),
        .fall_q   (fall_cap[n]),
        .rise_ok  (rise_ok[n]),
        .pend     (pend[n])
      );
    end
  endgenerate

  assign req0_vec = pend & mask_q & assign_q;
  assign req1_vec = pend & mask_q & ~assign_q;
  assign wake_vec = pend & wake_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq0 <= 1'b0;
      irq1 <= 1'b0;
      wake <= 1'b0;
    end else begin
      irq0 <= |req0_vec;
      irq1 <= |req1_vec;
      wake <= |wake_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                          test_q <= '0;
    else if (wr_en && addr == A_TEST) test_q <= wdata;
  end

  // reads decode separately from writes: 0x54/0x5C are clear-only on write
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_SC; i++) begin
      if (addr == ADDR_W'(SC_BASE + SC_STRIDE * i)) rd_mux = bank_q[i];
    end
    if (addr == A_PEND0) rd_mux = req0_vec;
    if (addr == A_PEND1) rd_mux = req1_vec;
    if (addr == A_RISE)  rd_mux = rise_cap;
    if (addr == A_FALL)  rd_mux = fall_cap;
    if (addr == A_TEST)  rd_mux = test_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NSRC-1:0]   wdata,
  input logic [NSRC-1:0]   rdata,
  input logic              irq0,
  input logic              irq1,
  input logic              wake,
  input logic [NSRC-1:0]   mask_q,
  input logic [NSRC-1:0]   assign_q,
  input logic [NSRC-1:0]   rise_cap,
  input logic [NSRC-1:0]   rise_ok
);
  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq0 && !irq1 && !wake));

  // R2
  mask_set_sticks_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && $past(addr) == ADDR_W'('h70))
      |-> ((mask_q & $past(wdata)) == $past(wdata)));

  // R10
  capture_only_in_edge_mode_chk: assert property (@(posedge clk) disable iff (rst)
    ((rise_cap & ~$past(rise_cap) & ~$past(rise_ok)) == '0));

  // R8
  irq0_needs_mask_chk: assert property (@(posedge clk) disable iff (rst)
    irq0 |-> $past(|(mask_q & assign_q)));

  // R7
  irq1_needs_route_chk: assert property (@(posedge clk) disable iff (rst)
    irq1 |-> $past(|(mask_q & ~assign_q)));

  // R9
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && $past(addr) == ADDR_W'('h84)) |-> (rdata == '0));
endmodule

bind irqc_top irqc_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .irq0     (irq0),
  .irq1     (irq1),
  .wake     (wake),
  .mask_q   (mask_q),
  .assign_q (assign_q),
  .rise_cap (rise_cap),
  .rise_ok  (rise_ok)
);

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
  localparam int unsigned NSRC = 32;
  localparam int unsigned AW   = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_in = '0;
  logic            wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [NSRC-1:0] wdata = '0;
  logic [NSRC-1:0] rdata;
  logic            irq0, irq1, wake;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  irqc_top #(.NSRC(NSRC), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .src_in(src_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq0(irq0), .irq1(irq1), .wake(wake)
  );

  task automatic chk(input string req, input logic [NSRC-1:0] act, input logic [NSRC-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [NSRC-1:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input int a, output logic [NSRC-1:0] d);
    @(negedge clk);
    addr = AW'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit exp_pend(int c, bit s, bit rc, bit fc);
    case (c)
      1: return rc;
      2: return fc;
      3: return rc | fc;
      5: return s;
      6: return !s;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(int c);
    if (c >= 1 && c <= 3) return "R3";
    if (c == 5 || c == 6) return "R4";
    return "R10";
  endfunction

  localparam int S = 5;

  task automatic check_src(input int c, input bit a, input bit s, input bit rc, input bit fc,
                           input string step);
    logic [NSRC-1:0] v;
    bit p;
    string t;
    p = exp_pend(c, s, rc, fc);
    t = $sformatf("%s/R7 code=%0d assign=%0d %s", tag_of(c), c, a, step);
    rd('h54, v); chk({t, " pend0"}, v, (p && a)  ? (1 << S) : '0);
    rd('h5C, v); chk({t, " pend1"}, v, (p && !a) ? (1 << S) : '0);
    chk({t, " irq0"}, NSRC'(irq0), NSRC'(p && a));
    chk({t, " irq1"}, NSRC'(irq1), NSRC'(p && !a));
    chk({t, " R8 wake"}, NSRC'(wake), NSRC'(p));
    rd('h78, v); chk({t, " R6 risecap"}, v, rc ? (1 << S) : '0);
    rd('h7C, v); chk({t, " R6 fallcap"}, v, fc ? (1 << S) : '0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    logic [NSRC-1:0] v;
    bit rc, fc;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq0", NSRC'(irq0), '0);
    chk("R1 irq1", NSRC'(irq1), '0);
    chk("R1 wake", NSRC'(wake), '0);
    for (int i = 0; i < 7; i++) begin
      rd('h40 + 8 * i, v);
      chk($sformatf("R1 reg %0h", 'h40 + 8 * i), v, (i == 3) ? '1 : '0);
    end
    rd('h78, v); chk("R1 risecap", v, '0);
    rd('h7C, v); chk("R1 fallcap", v, '0);
    rd('h80, v); chk("R1 test", v, '0);

    // R2 set/clear semantics and test register
    wr('h70, 32'hF0F0_00FF);
    wr('h74, 32'h0000_00F0);
    rd('h70, v); chk("R2 mask set/clear", v, 32'hF0F0_000F);
    wr('h70, 32'h0);
    rd('h70, v); chk("R2 zero write no change", v, 32'hF0F0_000F);
    wr('h5C, 32'h0000_FFFF);
    rd('h58, v); chk("R2 srcsel clear", v, 32'hFFFF_0000);
    wr('h80, 32'hA5C3_0011);
    rd('h80, v); chk("R2 test reg", v, 32'hA5C3_0011);

    // R9 unmapped reads and writes
    rd('h84, v); chk("R9 read 0x84", v, '0);
    rd('h74, v); chk("R9 read clear addr 0x74", v, '0);
    rd('h44, v); chk("R9 read clear addr 0x44", v, '0);
    wr('h90, '1);
    wr('hFC, '1);
    rd('h70, v); chk("R9 mask unchanged", v, 32'hF0F0_000F);
    rd('h40, v); chk("R9 cfg0 unchanged", v, '0);
    wr('h74, '1);
    wr('h80, '0);

    // Mode sweep: all eight codes, both routings, source S
    for (int c = 0; c < 8; c++) begin
      for (int a = 0; a < 2; a++) begin
        src_in[S] = 1'b0;
        idle(5);
        wr('h44, '1); wr('h4C, '1); wr('h54, '1);
        wr('h78, '1); wr('h7C, '1);
        wr('h74, '1); wr('h64, '1); wr('h6C, '1);
        if (c[0]) wr('h40, 1 << S);
        if (c[1]) wr('h48, 1 << S);
        if (c[2]) wr('h50, 1 << S);
        if (a != 0) wr('h60, 1 << S);
        wr('h70, 1 << S);
        wr('h68, 1 << S);
        idle(3);
        rc = 0; fc = 0;
        check_src(c, a[0], 1'b0, rc, fc, "idle");
        src_in[S] = 1'b1; idle(5);
        if (c == 1 || c == 3) rc = 1;
        check_src(c, a[0], 1'b1, rc, fc, "rise");
        src_in[S] = 1'b0; idle(5);
        if (c == 2 || c == 3) fc = 1;
        check_src(c, a[0], 1'b0, rc, fc, "fall");
        wr('h78, 1 << S); rc = 0; idle(2);
        check_src(c, a[0], 1'b0, rc, fc, "R5 rise-cleared");
        wr('h7C, 1 << S); fc = 0; idle(2);
        check_src(c, a[0], 1'b0, rc, fc, "fall-cleared");
      end
    end

    // R8 mask versus wake independence on source 7 in high-level mode
    wr('h44, '1); wr('h4C, '1); wr('h54, '1);
    wr('h74, '1); wr('h6C, '1); wr('h64, '1);
    wr('h40, 1 << 7); wr('h50, 1 << 7); wr('h60, 1 << 7);
    wr('h68, 1 << 7);
    src_in[7] = 1'b1; idle(5);
    chk("R8 masked irq0", NSRC'(irq0), '0);
    chk("R8 masked irq1", NSRC'(irq1), '0);
    rd('h54, v); chk("R8 masked pend0", v, '0);
    chk("R8 wake while masked", NSRC'(wake), 1);
    wr('h70, 1 << 7); wr('h6C, 1 << 7); idle(2);
    chk("R8 unmasked irq0", NSRC'(irq0), 1);
    chk("R8 wake disabled", NSRC'(wake), '0);
    src_in[7] = 1'b0; idle(5);

    // R11 latency: level mode three edges, edge mode four
    @(negedge clk);
    src_in[7] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R11 level not yet", NSRC'(irq0), '0);
    @(negedge clk);
    chk("R11 level third edge", NSRC'(irq0), 1);
    src_in[7] = 1'b0; idle(5);
    wr('h54, 1 << 7); wr('h78, '1);
    @(negedge clk);
    src_in[7] = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R11 edge not yet", NSRC'(irq0), '0);
    @(negedge clk);
    chk("R11 edge fourth edge", NSRC'(irq0), 1);
    wr('h78, 32'h0);
    idle(2);
    chk("R6 zero write keeps capture", NSRC'(irq0), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule